// File: doc/BRIEF.md
# Dynamic Bus Sizing Sequencer

This block sits between a 32-bit core-side requester and an external bus where the addressed device may be narrower than the data path. The core hands over one transfer: a word address, four byte enables, write data, a direction bit and a flag that marks write-back or copy-back traffic. The sequencer then runs as many external bus cycles as the device needs. Each cycle presents the byte enables still outstanding. Two active-low port-width inputs tell the sequencer whether the device is 8, 16 or 32 bits wide.

The width inputs and the ready input are sampled on every rising clock edge. The width value present at the edge where ready is seen decides which bytes that cycle retired. A transfer can therefore change its remaining cycle count while it is in flight. Read bytes arriving on the low lanes are steered into place in a result word. Write bytes are copied down onto the low lanes. The core sees a single completion pulse once the last byte has been moved.

Top module: `bus_width_sequencer`

## Requirements
- R1: After reset the sequencer is idle: req_ready is 1, while bus_active, bus_start and cpl_valid are 0.
- R2: With both width inputs high (32-bit port), every outstanding enabled byte retires at the first ready edge, and that bus cycle shows the request's full byte enables.
- R3: The width inputs are sampled on every clock while a bus cycle waits. Only the value at the ready edge counts. bus_be, bus_addr and bus_wdata stay constant from bus_start until ready.
- R4: A 16-bit port (bus_port16_n low, bus_port8_n high) retires the outstanding enabled bytes of the half-word (lanes 0-1 or lanes 2-3) that holds the lowest outstanding byte. A full-word request therefore takes two cycles.
- R5: An 8-bit port (bus_port8_n low) retires only the lowest outstanding byte. A full-word request therefore takes four cycles.
- R6: When both width inputs are low in the same clock, the 8-bit rule of R5 applies.
- R7: When req_writeback was 1 at acceptance, both width inputs are ignored and the transfer finishes in one bus cycle.
- R8: Every bus cycle's bus_be equals the request's enabled bytes that are still outstanding, so fewer enabled bytes need fewer cycles. A request with req_be = 0 runs no bus cycle and completes on the next clock.
- R9: Read steering: a 32-bit port supplies byte i on lane i, a 16-bit port on lane i mod 2, and an 8-bit port on lane 0. cpl_rdata holds zero in bytes not enabled, and it is all zero for writes.
- R10: Write steering, with f the lowest outstanding byte index: bus_wdata[31:16] = wdata[31:16], bus_wdata[15:8] = wdata[31:24] if f >= 2 and wdata[15:8] otherwise, and bus_wdata[7:0] = wdata byte f.
- R11: cpl_valid pulses for one clock, on the clock after the ready edge that retires the last byte. In that clock bus_active is 0 and req_ready is 1.
- R12: A ready edge that leaves bytes outstanding is followed in the next clock by a new cycle, with bus_start high for its first clock and the same bus_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core transfer request, taken when req_ready is 1 |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_addr | input | ADDR_W | Word address |
| req_be | input | 4 | Byte enables, bit i for byte i |
| req_wdata | input | 32 | Write data |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_writeback | input | 1 | Write-back or copy-back traffic, width sampling disabled |
| cpl_valid | output | 1 | One-clock completion pulse |
| cpl_rdata | output | 32 | Assembled read data |
| bus_start | output | 1 | First clock of an external bus cycle |
| bus_active | output | 1 | External bus cycle in progress |
| bus_addr | output | ADDR_W | External word address |
| bus_be | output | 4 | Outstanding byte enables |
| bus_write | output | 1 | Direction of the external cycle |
| bus_wdata | output | 32 | Steered write data |
| bus_rdata | input | 32 | Read data from the device |
| bus_ready | input | 1 | Device ready, ends the current bus cycle |
| bus_port8_n | input | 1 | Device is 8 bits wide, active low |
| bus_port16_n | input | 1 | Device is 16 bits wide, active low |

## Verification
The bench goes after width changes during wait states. A design that latched the width at bus_start instead of at the ready edge would retire the wrong bytes and show a wrong bus_be in the next cycle. It also drives both width inputs low together, writes and reads on sparse byte patterns such as lane 3 only or lanes 1 and 2, and write-back transfers facing an 8-bit port. A wrong priority, a half-word chosen from the wrong half, or a write-back that still splits would each show up as an extra or missing cycle, or as misplaced bytes in cpl_rdata or on the low write lanes. Empty requests check that no bus cycle is started and that completion still comes one clock later.

// File: rtl/bws_pkg.sv
package bws_pkg;
    localparam int LANES      = 4;
    localparam int BYTE_W     = 8;
    localparam int DATA_W     = LANES * BYTE_W;
    localparam int LANE_IDX_W = $clog2(LANES);

    typedef enum logic [1:0] {
        PW_32 = 2'd0,
        PW_16 = 2'd1,
        PW_8  = 2'd2
    } port_w_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUS  = 1'b1
    } seq_st_e;

    // Index of the lowest set bit; zero for an empty mask.
    function automatic logic [LANE_IDX_W-1:0] first_lane(input logic [LANES-1:0] m);
        logic [LANE_IDX_W-1:0] r;
        r = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (m[i]) r = LANE_IDX_W'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/bws_width_decode.sv
module bws_width_decode
    import bws_pkg::*;
(
    input  logic    port8_n,
    input  logic    port16_n,
    input  logic    suppress,
    output port_w_e width
);
    always_comb begin
        if (suppress)       width = PW_32;
        else if (!port8_n)  width = PW_8;
        else if (!port16_n) width = PW_16;
        else                width = PW_32;
    end
endmodule

// File: rtl/bws_lane_select.sv
module bws_lane_select
    import bws_pkg::*;
(
    input  logic [LANES-1:0]      rem,
    input  port_w_e               width,
    output logic [LANES-1:0]      done_mask,
    output logic [LANE_IDX_W-1:0] first_idx
);
    localparam int HALF_SHIFT = 1;

    always_comb begin
        first_idx = first_lane(rem);
        for (int i = 0; i < LANES; i++) begin
            unique case (width)
                PW_8:    done_mask[i] = rem[i] && (LANE_IDX_W'(i) == first_idx);
                PW_16:   done_mask[i] = rem[i] &&
                                        ((LANE_IDX_W'(i) >> HALF_SHIFT) == (first_idx >> HALF_SHIFT));
                default: done_mask[i] = rem[i];
            endcase
        end
    end
endmodule

// File: rtl/bws_read_merge.sv
module bws_read_merge
    import bws_pkg::*;
(
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic [LANES-1:0]  done_mask,
    input  port_w_e           width,
    output logic [DATA_W-1:0] merged
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] src;
        always_comb begin
            unique case (width)
                PW_16:   src = bus_rdata[BYTE_W*(g%2) +: BYTE_W];
                PW_8:    src = bus_rdata[BYTE_W-1:0];
                default: src = bus_rdata[BYTE_W*g +: BYTE_W];
            endcase
        end
        assign merged[BYTE_W*g +: BYTE_W] = done_mask[g] ? src : acc[BYTE_W*g +: BYTE_W];
    end
endmodule

// File: rtl/bws_write_steer.sv
module bws_write_steer
    import bws_pkg::*;
(
    input  logic [DATA_W-1:0]     wdata,
    input  logic [LANE_IDX_W-1:0] first_idx,
    output logic [DATA_W-1:0]     lanes
);
    localparam int HALF_W = DATA_W / 2;

    always_comb begin
        lanes[DATA_W-1:HALF_W] = wdata[DATA_W-1:HALF_W];
        lanes[HALF_W-1:BYTE_W] = first_idx[LANE_IDX_W-1] ? wdata[DATA_W-1 -: BYTE_W]
                                                         : wdata[HALF_W-1 -: BYTE_W];
        lanes[BYTE_W-1:0]      = wdata[{first_idx, 3'b000} +: BYTE_W];
    end
endmodule

// File: rtl/bus_width_sequencer.sv
module bus_width_sequencer
    import bws_pkg::*;
#(
    parameter int ADDR_W = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]  req_be,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_write,
    input  logic              req_writeback,
    output logic              cpl_valid,
    output logic [DATA_W-1:0] cpl_rdata,
    output logic              bus_start,
    output logic              bus_active,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [LANES-1:0]  bus_be,
    output logic              bus_write,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ready,
    input  logic              bus_port8_n,
    input  logic              bus_port16_n
);
    typedef struct packed {
        seq_st_e           st;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  rem;
        logic [DATA_W-1:0] wdata;
        logic              write;
        logic              wb;
        logic              start;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } seq_t;

    seq_t seq_d, seq_q;

    port_w_e               width;
    logic [LANES-1:0]      done_mask;
    logic [LANE_IDX_W-1:0] first_idx;
    logic [DATA_W-1:0]     merged;

    bws_width_decode u_width (
        .port8_n  (bus_port8_n),
        .port16_n (bus_port16_n),
        .suppress (seq_q.wb),
        .width    (width)
    );

    bws_lane_select u_select (
        .rem       (seq_q.rem),
        .width     (width),
        .done_mask (done_mask),
        .first_idx (first_idx)
    );

    bws_read_merge u_merge (
        .acc       (seq_q.rdata),
        .bus_rdata (bus_rdata),
        .done_mask (done_mask),
        .width     (width),
        .merged    (merged)
    );

    bws_write_steer u_steer (
        .wdata     (seq_q.wdata),
        .first_idx (first_idx),
        .lanes     (bus_wdata)
    );

    always_comb begin
        seq_d       = seq_q;
        seq_d.done  = 1'b0;
        seq_d.start = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    seq_d.addr  = req_addr;
                    seq_d.wdata = req_wdata;
                    seq_d.write = req_write;
                    seq_d.wb    = req_writeback;
                    seq_d.rdata = '0;
                    seq_d.rem   = req_be;
                    if (req_be == '0) begin
                        seq_d.done = 1'b1;
                    end else begin
                        seq_d.st    = ST_BUS;
                        seq_d.start = 1'b1;
                    end
                end
            end
            default: begin
                if (bus_ready) begin
                    if (!seq_q.write) seq_d.rdata = merged;
                    seq_d.rem = seq_q.rem & ~done_mask;
                    if ((seq_q.rem & ~done_mask) == '0) begin
                        seq_d.st   = ST_IDLE;
                        seq_d.done = 1'b1;
                    end else begin
                        seq_d.start = 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, addr: '0, rem: '0, wdata: '0, write: 1'b0,
                       wb: 1'b0, start: 1'b0, rdata: '0, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_ready  = (seq_q.st == ST_IDLE);
    assign cpl_valid  = seq_q.done;
    assign cpl_rdata  = seq_q.rdata;
    assign bus_start  = seq_q.start;
    assign bus_active = (seq_q.st == ST_BUS);
    assign bus_addr   = seq_q.addr;
    assign bus_be     = seq_q.rem;
    assign bus_write  = seq_q.write;

    AST_BE_HELD_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_active && !bus_start |-> $stable(bus_be) && $stable(bus_addr)) else $error("be moved"); // R3
    AST_HALF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        bus_active && bus_ready && !seq_q.wb && bus_port8_n && !bus_port16_n
        |=> !bus_active || (((bus_be & ~$past(bus_be)) == '0) && (bus_be != $past(bus_be)))) else $error("half"); // R4
    AST_BYTE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        bus_active && bus_ready && !seq_q.wb && !bus_port8_n && bus_port16_n && ($countones(bus_be) > 1)
        |=> $countones(bus_be) == $countones($past(bus_be)) - 1) else $error("byte"); // R5
    AST_BOTH_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_active && bus_ready && !seq_q.wb && !bus_port8_n && !bus_port16_n && ($countones(bus_be) > 1)
        |=> $countones(bus_be) == $countones($past(bus_be)) - 1) else $error("prio"); // R6
    AST_WB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_active && bus_ready && seq_q.wb |=> !bus_active && cpl_valid) else $error("wb"); // R7
    AST_BE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_active |-> bus_be != '0) else $error("empty be"); // R8
    AST_CPL_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid && $past(bus_active) |-> $past(bus_ready) && !bus_active && req_ready) else $error("cpl"); // R11
    AST_NEXT_CYCLE_START: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_active && bus_ready) && bus_active |-> bus_start && $stable(bus_addr)) else $error("start"); // R12
endmodule

// File: tb/sim_bus_width_sequencer.sv
module sim_bus_width_sequencer;
    localparam int AW = 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [3:0]    req_be = '0;
    logic [31:0]   req_wdata = '0;
    logic          req_write = 1'b0;
    logic          req_writeback = 1'b0;
    logic          cpl_valid;
    logic [31:0]   cpl_rdata;
    logic          bus_start, bus_active, bus_write;
    logic [AW-1:0] bus_addr;
    logic [3:0]    bus_be;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata = '0;
    logic          bus_ready = 1'b0;
    logic          bus_port8_n = 1'b1;
    logic          bus_port16_n = 1'b1;

    int nchk = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    bus_width_sequencer #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_be(req_be), .req_wdata(req_wdata), .req_write(req_write),
        .req_writeback(req_writeback), .cpl_valid(cpl_valid), .cpl_rdata(cpl_rdata),
        .bus_start(bus_start), .bus_active(bus_active), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_write(bus_write), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .bus_port8_n(bus_port8_n), .bus_port16_n(bus_port16_n)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
        end
    endtask

    // width code: 0 = 32-bit, 1 = 16-bit, 2 = 8-bit, 3 = both low
    task automatic set_w(input int code);
        bus_port8_n  = !(code == 2 || code == 3);
        bus_port16_n = !(code == 1 || code == 3);
    endtask

    function automatic int low_idx(input logic [3:0] m);
        for (int i = 0; i < 4; i++) if (m[i]) return i;
        return 0;
    endfunction

    function automatic logic [3:0] exp_mask(input logic [3:0] rem, input int code, input bit wb);
        int f;
        f = low_idx(rem);
        if (wb || code == 0) return rem;
        if (code == 1) return rem & ((f >= 2) ? 4'b1100 : 4'b0011);
        return 4'(1 << f);
    endfunction

    function automatic logic [31:0] exp_wlanes(input logic [31:0] w, input logic [3:0] rem);
        int f;
        logic [31:0] r;
        f = low_idx(rem);
        r[31:16] = w[31:16];
        r[15:8]  = (f >= 2) ? w[31:24] : w[15:8];
        r[7:0]   = w[8*f +: 8];
        return r;
    endfunction

    function automatic int src_lane(input int i, input int code, input bit wb);
        if (wb || code == 0) return i;
        if (code == 1) return i % 2;
        return 0;
    endfunction

    // mode: -1 random width per cycle, 0..3 fixed code, 4 = wait at 8-bit then ready at 32-bit
    task automatic run_txn(input logic [3:0] be, input bit wr, input bit wb, input int mode, input string tag);
        logic [3:0]  rem, m;
        logic [31:0] exp_rd;
        logic [AW-1:0] a;
        int code, nw, ncyc;
        a = AW'($urandom);
        @(negedge clk);
        chk(req_ready == 1'b1, "R11 ready before request", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_be = be; req_write = wr; req_writeback = wb;
        req_addr = a; req_wdata = $urandom;
        @(negedge clk);
        req_valid = 1'b0;
        rem = be; exp_rd = '0; ncyc = 0;
        if (be == 4'b0000)
            chk(bus_active == 1'b0, "R8 empty request starts no cycle", 32'(bus_active), 32'd0);
        while (rem != 4'b0000) begin
            chk(bus_active && bus_start, {tag, " R12 cycle start"}, {30'd0, bus_active, bus_start}, 32'd3);
            chk(bus_be == rem, {tag, " R8 bus_be outstanding"}, 32'(bus_be), 32'(rem));
            chk(bus_addr == a, {tag, " R12 address"}, 32'(bus_addr), 32'(a));
            if (ncyc == 0)
                chk(bus_be == be, {tag, " R2 first cycle full enables"}, 32'(bus_be), 32'(be));
            if (wr)
                chk(bus_wdata == exp_wlanes(req_wdata, rem), {tag, " R10 write lanes"},
                    bus_wdata, exp_wlanes(req_wdata, rem));
            nw = (mode == 4) ? 2 : int'($urandom_range(0, 2));
            for (int k = 0; k < nw; k++) begin
                set_w((mode == 4) ? 2 : int'($urandom_range(0, 3)));
                bus_ready = 1'b0;
                @(negedge clk);
                chk(bus_be == rem && !bus_start, {tag, " R3 held while waiting"}, 32'(bus_be), 32'(rem));
            end
            code = (mode < 0) ? int'($urandom_range(0, 3)) : ((mode == 4) ? 0 : mode);
            set_w(code);
            bus_ready = 1'b1;
            bus_rdata = $urandom;
            m = exp_mask(rem, code, wb);
            for (int i = 0; i < 4; i++)
                if (m[i]) exp_rd[8*i +: 8] = bus_rdata[8*src_lane(i, code, wb) +: 8];
            rem = rem & ~m;
            ncyc++;
            @(negedge clk);
            bus_ready = 1'b0;
            set_w($urandom_range(0, 3));
        end
        chk(cpl_valid == 1'b1, {tag, " R11 completion pulse"}, 32'(cpl_valid), 32'd1);
        chk(bus_active == 1'b0 && req_ready == 1'b1, {tag, " R11 idle at completion"},
            {30'd0, bus_active, req_ready}, 32'd1);
        chk(cpl_rdata == (wr ? 32'd0 : exp_rd), {tag, " R9 read assembly"}, cpl_rdata, wr ? 32'd0 : exp_rd);
        if (wb && be != 0)
            chk(ncyc == 1, {tag, " R7 one cycle write-back"}, 32'(ncyc), 32'd1);
        @(negedge clk);
        chk(cpl_valid == 1'b0, {tag, " R11 pulse is one clock"}, 32'(cpl_valid), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 reset ready", 32'(req_ready), 32'd1);
        chk(bus_active == 1'b0 && bus_start == 1'b0, "R1 reset bus idle", {30'd0, bus_active, bus_start}, 32'd0);
        chk(cpl_valid == 1'b0, "R1 reset no completion", 32'(cpl_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        run_txn(4'hF, 1'b0, 1'b0, 0, "R2 word read");
        run_txn(4'hF, 1'b1, 1'b0, 0, "R2 word write");
        run_txn(4'hF, 1'b0, 1'b0, 1, "R4 half read");
        run_txn(4'hF, 1'b1, 1'b0, 1, "R4 half write");
        run_txn(4'b0110, 1'b0, 1'b0, 1, "R4 mid lanes");
        run_txn(4'b1000, 1'b1, 1'b0, 1, "R4 top lane");
        run_txn(4'hF, 1'b0, 1'b0, 2, "R5 byte read");
        run_txn(4'hF, 1'b1, 1'b0, 2, "R5 byte write");
        run_txn(4'hF, 1'b0, 1'b0, 3, "R6 both low");
        run_txn(4'b1010, 1'b1, 1'b0, 3, "R6 sparse");
        run_txn(4'hF, 1'b1, 1'b0, 4, "R3 width change");
        run_txn(4'hF, 1'b1, 1'b1, 2, "R7 wb byte port");
        run_txn(4'hF, 1'b0, 1'b1, 3, "R7 wb both low");
        run_txn(4'b0000, 1'b0, 1'b0, 0, "R8 empty");
        run_txn(4'b1100, 1'b0, 1'b0, 2, "R8 upper half");
        for (int t = 0; t < 400; t++)
            run_txn(4'($urandom), 1'($urandom), ($urandom_range(0, 7) == 0), -1, "R9 random");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule